// File: doc/BRIEF.md
# Multi-Mode Timer Base Counter

This block is a free-running 16-bit time base for a larger chip. It picks one of four incoming clock-rate signals, brings the chosen one into the system clock domain, divides its rising edges by 1, 2, 4 or 8, and steps a counter on every divided edge. The counter can be halted, run as a period timer that restarts from zero, run over the full 16-bit range, or run as a symmetric triangle that climbs to a period value and descends back to zero.

Software drives a small control word (mode, divider, source, clear, interrupt enable, overflow flag) and a separate period register. The block exposes the live count, the counting direction, a one-cycle strobe when the count arrives at the period value, a sticky overflow flag and an interrupt request. Capture/compare channels downstream use the count and the period strobe.

A two-state direction machine drives the counting: `PH_RISE` (counting up) and `PH_FALL` (counting down). Transitions: `PH_RISE`→`PH_FALL` when a step finds the count at or above the period in up/down mode (unless that step lands on 0); `PH_FALL`→`PH_RISE` when a step lands on 0 or finds the count already at 0; any state→`PH_RISE` on clear, or on a step in any mode other than up/down.

Top module: `tick_base_timer`

## Requirements
- R1: The source field, control bits [5:4], selects `src_in[0..3]` by value 0..3; after a two-stage synchroniser only rising edges of the selected input advance the divider, and edges on the other inputs have no effect.
- R2: The divider field, control bits [3:2], makes the counter step once every 1, 2, 4 or 8 selected edges for values 0, 1, 2, 3.
- R3: Mode value 0 (control bits [1:0]) is stop: the count and the divider state hold.
- R4: Mode 1 is up: the count goes 0,1,...,P then 0, where P is the period register; `period_hit` pulses for one cycle as the count becomes P, and the step P→0 sets the overflow flag.
- R5: Mode 2 is continuous: the count runs to 0xFFFF and the next step gives 0 and sets the overflow flag.
- R6: Mode 3 is up/down: the count climbs to P, then falls to 0, then climbs again; `count_down` is 1 while falling, and a falling step that reaches 0 sets the overflow flag.
- R7: Writing 1 to control bit 6 (clear) sets the count to 0, the divider state to 0 and the direction to up on the next cycle; bit 6 always reads 0.
- R8: The overflow flag (control bit 8) stays 1 until a control write with bit 8 = 0; an overflow event in the same cycle as that write wins and leaves the flag at 1.
- R9: `irq` is 1 exactly when the overflow flag and the interrupt enable (control bit 7) are both 1.
- R10: With P = 0 in mode 1 or 3 the count stays at 0 and neither `period_hit` nor the overflow flag is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 4 | Four candidate count sources |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 9 | Control word write data |
| ctl_rdata | output | 9 | Control word read-back (clear bit reads 0) |
| per_we | input | 1 | Period register write strobe |
| per_wdata | input | 16 | Period register write data |
| count | output | 16 | Current count |
| count_down | output | 1 | 1 while counting down |
| period_hit | output | 1 | One-cycle strobe when the count becomes P |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
The counter is driven by slow, widely spaced pulses on each of the four sources in turn, including pulses on unselected sources, which separates source selection from divider ratio and shows the divider state surviving a stop. Short periods (0, 2, 3, 5) in up and up/down modes distinguish the wrap point, the turn-around point and the degenerate zero period, while a long burst of back-to-back edges walks continuous mode through the full 16-bit range to its wrap. One edge is timed to land in the same cycle as a software flag clear to show the event wins, and a clear issued while counting down shows that direction and count both return to their start values.

// File: rtl/tbt_pkg.sv
package tbt_pkg;

    typedef enum logic [1:0] {
        MODE_STOP = 2'd0,
        MODE_UP   = 2'd1,
        MODE_CONT = 2'd2,
        MODE_UPDN = 2'd3
    } run_mode_e;

    typedef enum logic {
        PH_RISE = 1'b0,
        PH_FALL = 1'b1
    } phase_e;

    // control word layout
    localparam int MODE_LSB = 0;
    localparam int DIV_LSB  = 2;
    localparam int SRC_LSB  = 4;
    localparam int CLR_BIT  = 6;
    localparam int IE_BIT   = 7;
    localparam int FLAG_BIT = 8;
    localparam int CTL_W    = FLAG_BIT + 1;

endpackage

// File: rtl/tbt_src_sync.sv
module tbt_src_sync #(
    parameter int N_SRC  = 4,
    parameter int STAGES = 2,
    localparam int SEL_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_in,
    input  logic [SEL_W-1:0] sel,
    output logic             rise_o
);
    logic [N_SRC-1:0] synced;
    logic             sel_prev;
    logic             sel_now;

    for (genvar g = 0; g < N_SRC; g++) begin : g_sync
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], src_in[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    assign sel_now = synced[sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_prev <= 1'b0;
        else        sel_prev <= sel_now;
    end

    assign rise_o = sel_now & ~sel_prev;
endmodule

// File: rtl/tbt_prescaler.sv
module tbt_prescaler #(
    parameter int DIV_W = 2,
    localparam int PRE_W = (1 << DIV_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             tick_in,
    input  logic [DIV_W-1:0] div,
    output logic             tick_out
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;
    logic             at_end;

    assign mask     = ~({PRE_W{1'b1}} << div);
    assign at_end   = (pre_q == mask);
    assign tick_out = run & tick_in & at_end & ~clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr) begin
            pre_q <= '0;
        end else if (run && tick_in) begin
            pre_q <= at_end ? '0 : pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/tbt_count_fsm.sv
module tbt_count_fsm
    import tbt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      tick,
    input  run_mode_e mode,
    input  logic [W-1:0] period,
    output logic [W-1:0] count,
    output logic      falling,
    output logic      hit_stb,
    output logic      wrap_evt
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] TOP  = '1;

    phase_e       state, nxt_state;
    logic [W-1:0] nxt_cnt;
    logic         ev_hit;
    logic         ev_wrap;
    logic         per_zero;

    assign per_zero = (period == ZERO);

    always_comb begin
        nxt_state = state;
        nxt_cnt   = count;
        ev_hit    = 1'b0;
        ev_wrap   = 1'b0;
        if (clr) begin
            nxt_state = PH_RISE;
            nxt_cnt   = ZERO;
        end else if (tick) begin
            unique case (mode)
                MODE_STOP: begin
                    nxt_cnt = count;
                end
                MODE_CONT: begin
                    nxt_state = PH_RISE;
                    nxt_cnt   = count + ONE;
                    ev_wrap   = (count == TOP);
                    ev_hit    = ((count + ONE) == period);
                end
                MODE_UP: begin
                    nxt_state = PH_RISE;
                    if (per_zero) begin
                        nxt_cnt = ZERO;
                    end else if (count >= period) begin
                        nxt_cnt = ZERO;
                        ev_wrap = 1'b1;
                    end else begin
                        nxt_cnt = count + ONE;
                        ev_hit  = ((count + ONE) == period);
                    end
                end
                MODE_UPDN: begin
                    if (per_zero) begin
                        nxt_state = PH_RISE;
                        nxt_cnt   = ZERO;
                    end else begin
                        unique case (state)
                            PH_RISE: begin
                                if (count < period) begin
                                    nxt_cnt = count + ONE;
                                    ev_hit  = ((count + ONE) == period);
                                end else begin
                                    nxt_cnt = count - ONE;
                                    if (count == ONE) begin
                                        ev_wrap   = 1'b1;
                                        nxt_state = PH_RISE;
                                    end else begin
                                        nxt_state = PH_FALL;
                                    end
                                end
                            end
                            PH_FALL: begin
                                if (count == ZERO) begin
                                    nxt_cnt   = ONE;
                                    nxt_state = PH_RISE;
                                    ev_hit    = (period == ONE);
                                end else begin
                                    nxt_cnt = count - ONE;
                                    if (count == ONE) begin
                                        ev_wrap   = 1'b1;
                                        nxt_state = PH_RISE;
                                    end
                                end
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_RISE;
        else        state <= nxt_state;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count   <= ZERO;
            hit_stb <= 1'b0;
        end else begin
            count   <= nxt_cnt;
            hit_stb <= ev_hit;
        end
    end

    assign falling  = (state == PH_FALL);
    assign wrap_evt = ev_wrap;
endmodule

// File: rtl/tick_base_timer.sv
module tick_base_timer
    import tbt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       src_in,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    input  logic             per_we,
    input  logic [CNT_W-1:0] per_wdata,
    output logic [CNT_W-1:0] count,
    output logic             count_down,
    output logic             period_hit,
    output logic             ovf_flag,
    output logic             irq
);
    run_mode_e        mode_q;
    logic [1:0]       div_q;
    logic [1:0]       src_q;
    logic             ie_q;
    logic             flag_q;
    logic [CNT_W-1:0] period_q;
    logic             clr;
    logic             src_rise;
    logic             step;
    logic             wrap_evt;

    assign clr = ctl_we & ctl_wdata[CLR_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_STOP;
            div_q  <= '0;
            src_q  <= '0;
            ie_q   <= 1'b0;
        end else if (ctl_we) begin
            mode_q <= run_mode_e'(ctl_wdata[MODE_LSB +: 2]);
            div_q  <= ctl_wdata[DIV_LSB +: 2];
            src_q  <= ctl_wdata[SRC_LSB +: 2];
            ie_q   <= ctl_wdata[IE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (wrap_evt) flag_q <= 1'b1;
        else if (ctl_we)   flag_q <= ctl_wdata[FLAG_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      period_q <= '0;
        else if (per_we) period_q <= per_wdata;
    end

    tbt_src_sync #(.N_SRC(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .src_in(src_in),
        .sel   (src_q),
        .rise_o(src_rise)
    );

    tbt_prescaler #(.DIV_W(2)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .run     (mode_q != MODE_STOP),
        .tick_in (src_rise),
        .div     (div_q),
        .tick_out(step)
    );

    tbt_count_fsm #(.W(CNT_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .tick    (step),
        .mode    (mode_q),
        .period  (period_q),
        .count   (count),
        .falling (count_down),
        .hit_stb (period_hit),
        .wrap_evt(wrap_evt)
    );

    always_comb begin
        ctl_rdata                   = '0;
        ctl_rdata[MODE_LSB +: 2]    = mode_q;
        ctl_rdata[DIV_LSB +: 2]     = div_q;
        ctl_rdata[SRC_LSB +: 2]     = src_q;
        ctl_rdata[IE_BIT]           = ie_q;
        ctl_rdata[FLAG_BIT]         = flag_q;
    end

    assign ovf_flag = flag_q;
    assign irq      = flag_q & ie_q;
endmodule

// File: rtl/tbt_checker.sv
module tbt_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ctl_we,
    input logic         clr_bit,
    input logic         per_we,
    input logic [1:0]   mode,
    input logic [W-1:0] period,
    input logic [W-1:0] count,
    input logic         count_down,
    input logic         period_hit,
    input logic         ovf_flag,
    input logic         ie,
    input logic         irq
);
    a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && clr_bit) |=> (count == '0 && !count_down));

    a_r4_hit_at_period: assert property (@(posedge clk) disable iff (!rst_n)
        (period_hit && !$past(per_we)) |-> (count == period));

    a_r3_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && !ctl_we) |=> $stable(count));

    a_r10_zero_period: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd1 || mode == 2'd3) && period == '0 && count == '0 && !ctl_we && !per_we)
        |=> (count == '0 && !period_hit));

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ctl_we) |=> ovf_flag);

    a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (ovf_flag && ie));
endmodule

bind tick_base_timer tbt_checker #(.W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .clr_bit   (ctl_wdata[tbt_pkg::CLR_BIT]),
    .per_we    (per_we),
    .mode      (mode_q),
    .period    (period_q),
    .count     (count),
    .count_down(count_down),
    .period_hit(period_hit),
    .ovf_flag  (ovf_flag),
    .ie        (ie_q),
    .irq       (irq)
);

// File: tb/test_tick_base_timer.sv
module test_tick_base_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_in = '0;
    logic        ctl_we = 1'b0;
    logic [8:0]  ctl_wdata = '0;
    logic [8:0]  ctl_rdata;
    logic        per_we = 1'b0;
    logic [15:0] per_wdata = '0;
    logic [15:0] count;
    logic        count_down, period_hit, ovf_flag, irq;

    int n_chk = 0;
    int n_fail = 0;
    int hit_seen = 0;
    int hit_base = 0;

    typedef struct {
        string       tag;
        logic [15:0] cnt;
        logic        dn;
        logic        flg;
        logic        irq;
        int          hits;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    tick_base_timer i_tick_base_timer (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .per_we(per_we), .per_wdata(per_wdata),
        .count(count), .count_down(count_down), .period_hit(period_hit),
        .ovf_flag(ovf_flag), .irq(irq)
    );

    always @(posedge clk) if (rst_n && period_hit) hit_seen <= hit_seen + 1;

    // monitor: pops expected items and compares
    always @(negedge clk) begin
        exp_t e;
        while (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            n_chk++;
            if (count !== e.cnt || count_down !== e.dn || ovf_flag !== e.flg ||
                irq !== e.irq || (hit_seen - hit_base) != e.hits) begin
                n_fail++;
                $display("FAIL %s: got cnt=%h dn=%b flag=%b irq=%b hits=%0d, expected cnt=%h dn=%b flag=%b irq=%b hits=%0d",
                         e.tag, count, count_down, ovf_flag, irq, hit_seen - hit_base,
                         e.cnt, e.dn, e.flg, e.irq, e.hits);
            end
        end
    end

    function automatic logic [8:0] cw(input int mode, input int dv, input int src,
                                      input bit clr, input bit ie, input bit flg);
        logic [8:0] w;
        w = '0;
        w[1:0] = 2'(mode);
        w[3:2] = 2'(dv);
        w[5:4] = 2'(src);
        w[6]   = clr;
        w[7]   = ie;
        w[8]   = flg;
        return w;
    endfunction

    task automatic expect_now(input string tag, input logic [15:0] c, input logic d,
                              input logic f, input logic q, input int h);
        exp_t e;
        e.tag = tag; e.cnt = c; e.dn = d; e.flg = f; e.irq = q; e.hits = h;
        sb_q.push_back(e);
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_val(input string tag, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s: got %0h, expected %0h", tag, act, exp_v);
        end
    endtask

    task automatic wr_ctl(input logic [8:0] w);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = w;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wr_per(input logic [15:0] p);
        @(negedge clk); per_we = 1'b1; per_wdata = p;
        @(negedge clk); per_we = 1'b0;
    endtask

    task automatic pulses(input int sel, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); src_in[sel] = 1'b1;
            @(negedge clk);
            @(negedge clk); src_in[sel] = 1'b0;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic mark();
        @(negedge clk); hit_base = hit_seen;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk_val("R7 reset ctl_rdata", int'(ctl_rdata), 0);
        expect_now("R9 reset", 16'h0, 0, 0, 0, 0);

        // R4 up mode, P=5, source 0
        wr_per(16'd5);
        mark();
        wr_ctl(cw(1, 0, 0, 0, 0, 0));
        pulses(0, 7);
        expect_now("R4 up wrap", 16'd1, 0, 1, 0, 1);
        // R1 unselected sources ignored
        pulses(1, 3);
        pulses(3, 2);
        expect_now("R1 unselected", 16'd1, 0, 1, 0, 1);

        // R9 irq, R8 flag clear by write
        wr_ctl(cw(1, 0, 0, 0, 1, 1));
        expect_now("R9 irq on", 16'd1, 0, 1, 1, 1);
        wr_ctl(cw(1, 0, 0, 0, 1, 0));
        expect_now("R8 flag cleared", 16'd1, 0, 0, 0, 1);

        // R2 divide by 4 on source 2, with R7 clear
        wr_per(16'd100);
        mark();
        wr_ctl(cw(1, 2, 2, 1, 0, 0));
        expect_now("R7 clear count", 16'd0, 0, 0, 0, 0);
        pulses(2, 10);
        expect_now("R2 div4", 16'd2, 0, 0, 0, 0);

        // R3 stop holds count and divider state
        wr_ctl(cw(0, 2, 2, 0, 0, 0));
        pulses(2, 5);
        expect_now("R3 stop", 16'd2, 0, 0, 0, 0);
        wr_ctl(cw(1, 2, 2, 0, 0, 0));
        pulses(2, 2);
        expect_now("R3 resume prescaler kept", 16'd3, 0, 0, 0, 0);

        // R6 up/down, P=3, source 3
        wr_per(16'd3);
        mark();
        wr_ctl(cw(3, 0, 3, 1, 0, 0));
        pulses(3, 4);
        expect_now("R6 turn down", 16'd2, 1, 0, 0, 1);
        pulses(3, 3);
        expect_now("R6 bottom flag", 16'd1, 0, 1, 0, 1);
        pulses(3, 2);
        expect_now("R6 second top", 16'd3, 0, 1, 0, 2);

        // R7 clear while falling
        wr_ctl(cw(3, 0, 3, 0, 0, 0));
        pulses(3, 1);
        expect_now("R6 falling again", 16'd2, 1, 0, 0, 2);
        wr_ctl(cw(3, 0, 3, 1, 0, 0));
        expect_now("R7 clear direction", 16'd0, 0, 0, 0, 2);
        chk_val("R7 clear bit reads 0", int'(ctl_rdata[6]), 0);

        // R10 zero period
        wr_per(16'd0);
        mark();
        wr_ctl(cw(1, 0, 0, 1, 0, 0));
        pulses(0, 5);
        expect_now("R10 up P=0", 16'd0, 0, 0, 0, 0);
        wr_ctl(cw(3, 0, 0, 1, 0, 0));
        pulses(0, 3);
        expect_now("R10 updown P=0", 16'd0, 0, 0, 0, 0);

        // R8 event beats software clear in the same cycle
        wr_per(16'd2);
        mark();
        wr_ctl(cw(1, 0, 0, 1, 0, 0));
        pulses(0, 2);
        expect_now("R4 at P=2", 16'd2, 0, 0, 0, 1);
        @(negedge clk); src_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = cw(1, 0, 0, 0, 0, 0);
        @(negedge clk); ctl_we = 1'b0; src_in[0] = 1'b0;
        repeat (4) @(negedge clk);
        expect_now("R8 event priority", 16'd0, 0, 1, 0, 1);

        // R5 continuous full range
        wr_per(16'd3);
        mark();
        wr_ctl(cw(2, 0, 0, 1, 0, 0));
        for (int i = 0; i < 65535; i++) begin
            @(negedge clk); src_in[0] = 1'b1;
            @(negedge clk); src_in[0] = 1'b0;
        end
        repeat (4) @(negedge clk);
        expect_now("R5 at top", 16'hFFFF, 0, 0, 0, 1);
        pulses(0, 1);
        expect_now("R5 wrap", 16'h0000, 0, 1, 0, 1);

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule